// File: doc/BRIEF.md
# Sub-word Writable Data RAM

This block is a small data memory of 256 words, each 32 bits wide. It is read without a clock: the addressed word appears on the read port as soon as the address settles. It is written on the rising clock edge. The address is a byte address. The upper bits pick the word, and the two lowest bits pick the lane inside that word.

A two-bit mode code chooses the write size. The options are no write, one byte, one half-word or the whole word. For narrow writes, the low bits of the write data are steered into the lane chosen by the address. Lanes that are not chosen keep their contents. A processor data path uses the block as its load/store memory: stores of any width go in through one data port, and loads are taken from the read port in the same cycle.

Top module: `subword_ram`

## Requirements
- R1: The memory holds 256 independent 32-bit words. Address bits [9:2] pick the word, so writing one word leaves every other word unchanged.
- R2: Mode code 2'b00 writes nothing, whatever the data and address inputs hold.
- R3: Mode code 2'b01 is a byte write. It stores data bits [7:0] into lane k = addr[1:0], which is word bits [8k+7:8k].
- R4: Mode code 2'b11 is a half-word write. It stores data bits [15:0] into word bits [15:0] when addr[1]=0, and into word bits [31:16] when addr[1]=1. addr[0] has no effect on this write.
- R5: Mode code 2'b10 is a word write. It stores all 32 data bits, and addr[1:0] has no effect on this write.
- R6: During a byte or half-word write, every lane that is not selected keeps its previous contents.
- R7: The read output shows the word selected by addr[9:2] within the same cycle the address is applied, with no clock edge in between.
- R8: A write takes effect at the rising clock edge. Before that edge the read port shows the old word. In the following cycle it shows the merged, updated word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; writes take effect on the rising edge |
| addr | input | 10 | Byte address: [9:2] selects the word, [1:0] selects the lane |
| wdata | input | 32 | Write data, taken from the low bits for narrow writes |
| wmode | input | 2 | Write size: 00 none, 01 byte, 11 half-word, 10 word |
| rdata | output | 32 | Combinational read of the addressed word |

## Verification
First, every word is loaded with a distinct pattern and read back. This separates correct word decoding from aliasing between words, and it exercises the lowest and highest words. Next, a word is loaded with a known background and then written with byte writes to each of the four lanes in turn. The same is done with half-word writes to both halves, using both values of addr[0]. Because the data sent in each step differs from the background, these steps show whether the lane steering is right and whether the other lanes are kept. Word writes with non-zero low address bits, and mode-00 cycles that carry data, show that the ignored address bits and the no-write code really do nothing. Each write cycle is read both before and after its edge, which separates write-through timing from a correct update at the edge.

// File: rtl/subword_ram.sv
module subword_ram #(
  parameter int WORD_AW = 8
) (
  input  logic                 clk,
  input  logic [WORD_AW+1:0]   addr,
  input  logic [31:0]          wdata,
  input  logic [1:0]           wmode,
  output logic [31:0]          rdata
);
  localparam int DEPTH = 1 << WORD_AW;
  localparam int LANES = 4;

  logic [31:0]        mem [DEPTH];
  logic [WORD_AW-1:0] idx;
  logic [LANES-1:0]   lane_en;
  logic [31:0]        lane_data;

  assign idx = addr[WORD_AW+1:2];

  always_comb begin
    case (wmode)
      2'b01:   lane_en = 4'b0001 << addr[1:0];
      2'b11:   lane_en = addr[1] ? 4'b1100 : 4'b0011;
      2'b10:   lane_en = 4'b1111;
      default: lane_en = 4'b0000;
    endcase
  end

  assign lane_data = (wmode == 2'b01) ? {4{wdata[7:0]}}  :
                     (wmode == 2'b11) ? {2{wdata[15:0]}} : wdata;

  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++) begin
      if (lane_en[g]) mem[idx][8*g +: 8] <= lane_data[8*g +: 8];
    end
  end

  assign rdata = mem[idx];
endmodule

module subword_ram_chk #(
  parameter int WORD_AW = 8
) (
  input logic               clk,
  input logic [WORD_AW+1:0] addr,
  input logic [31:0]        wdata,
  input logic [1:0]         wmode,
  input logic [31:0]        rdata
);
  logic               seen = 1'b0;
  logic [WORD_AW+1:0] p_addr;
  logic [31:0]        p_wdata;
  logic [31:0]        p_rdata;
  logic [1:0]         p_mode;
  logic [31:0]        p_mask;
  logic               same;

  always_ff @(posedge clk) begin
    seen    <= 1'b1;
    p_addr  <= addr;
    p_wdata <= wdata;
    p_rdata <= rdata;
    p_mode  <= wmode;
  end

  always_comb begin
    p_mask = '0;
    if (p_mode == 2'b01) p_mask[8*p_addr[1:0] +: 8] = 8'hFF;
    if (p_mode == 2'b11) p_mask = p_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
  end

  assign same = (p_addr[WORD_AW+1:2] == addr[WORD_AW+1:2]);

  a_r2_no_write: assert property (@(posedge clk) disable iff (!seen)
    (same && p_mode == 2'b00) |-> (rdata === p_rdata));
  a_r3_byte_lane: assert property (@(posedge clk) disable iff (!seen)
    (same && p_mode == 2'b01) |-> (rdata[8*p_addr[1:0] +: 8] === p_wdata[7:0]));
  a_r4_half_lane: assert property (@(posedge clk) disable iff (!seen)
    (same && p_mode == 2'b11) |->
      ((p_addr[1] ? rdata[31:16] : rdata[15:0]) === p_wdata[15:0]));
  a_r5_full_word: assert property (@(posedge clk) disable iff (!seen)
    (same && p_mode == 2'b10) |-> (rdata === p_wdata));
  a_r6_keep_lanes: assert property (@(posedge clk) disable iff (!seen)
    (same && p_mode[0]) |-> ((rdata & ~p_mask) === (p_rdata & ~p_mask)));
endmodule

bind subword_ram subword_ram_chk #(.WORD_AW(WORD_AW)) u_chk (
  .clk(clk), .addr(addr), .wdata(wdata), .wmode(wmode), .rdata(rdata)
);

// File: tb/subword_ram_tb.sv
module subword_ram_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  wmode = 2'b00;
  logic [31:0] rdata;

  logic [31:0] model [256];
  logic [31:0] q_exp [$];
  string       q_tag [$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_ram u_dut (.clk(clk), .addr(addr), .wdata(wdata), .wmode(wmode), .rdata(rdata));

  // Driver: one operation per cycle; expected read for that cycle is the pre-edge word (R7, R8)
  task automatic op(input logic [1:0] m, input logic [9:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    wmode = m; addr = a; wdata = d;
    q_exp.push_back(model[a[9:2]]);
    q_tag.push_back(tag);
    case (m)
      2'b01: model[a[9:2]][8*a[1:0] +: 8] = d[7:0];
      2'b11: if (a[1]) model[a[9:2]][31:16] = d[15:0]; else model[a[9:2]][15:0] = d[15:0];
      2'b10: model[a[9:2]] = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    op(2'b00, a, 32'hDEAD_BEEF, tag);
  endtask

  // Monitor: checks mid-cycle, away from both edges
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q_exp.size() > 0) begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected=%h (addr=%h)", t, rdata, e, addr);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: fill every word with a distinct pattern, then read each back
    for (int i = 0; i < 256; i++) op(2'b10, 10'(i*4), 32'hA500_0000 ^ (i * 32'h0101_0103), "R1");
    for (int i = 0; i < 256; i++) rd(10'(i*4 + (i % 4)), "R1");
    rd(10'h000, "R1");
    rd(10'h3FF, "R1");

    // R2: mode 00 with data present leaves the word intact
    op(2'b00, 10'h040, 32'h1234_5678, "R2");
    rd(10'h040, "R2");

    // R3 / R6: byte writes to each lane over a known background
    op(2'b10, 10'h080, 32'h1122_3344, "R5");
    for (int k = 0; k < 4; k++) begin
      op(2'b01, 10'(10'h080 + k), 32'hFFFF_FF00 | (8'hC0 + k), "R3");
      rd(10'h080, "R6");
    end

    // R4 / R6: half-word writes, both halves, addr[0] set and clear
    op(2'b10, 10'h100, 32'hCAFE_F00D, "R5");
    op(2'b11, 10'h101, 32'h5555_BEEF, "R4");
    rd(10'h100, "R6");
    op(2'b11, 10'h103, 32'hAAAA_1357, "R4");
    rd(10'h100, "R4");
    op(2'b11, 10'h102, 32'h0000_2468, "R4");
    rd(10'h101, "R6");

    // R5: word write with low address bits set
    op(2'b10, 10'h1C3, 32'h0BAD_F00D, "R5");
    rd(10'h1C0, "R5");
    rd(10'h1C4, "R1");

    // R8: back-to-back writes to one word, each read before its edge
    op(2'b10, 10'h200, 32'h0000_0000, "R8");
    op(2'b01, 10'h201, 32'h0000_00AB, "R8");
    op(2'b11, 10'h202, 32'h0000_CDEF, "R8");
    op(2'b01, 10'h200, 32'h0000_0012, "R8");
    rd(10'h200, "R8");

    // R7: address changes each cycle with no write
    rd(10'h3FC, "R7");
    rd(10'h004, "R7");
    rd(10'h3FC, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule